// File: doc/BRIEF.md
# Privileged Entry and Return Sequencer

This block is the multi-cycle sequencer a 16-bit processor uses to enter an interrupt or trap handler and to leave it with a return-from-interrupt (RTI). It owns the status word, the live stack pointer, and the two parked stack pointers for user and supervisor code. The status word has three meaningful fields: the mode bit in bit 15 (1 = user, 0 = supervisor), a 3-bit priority in bits [10:8], and a 3-bit condition code in bits [2:0]. All other bits read as zero.

On an entry request it moves to the supervisor stack if needed, saves the status word and a return address there, and raises privilege. It then reads the handler address from a vector table and hands that address to fetch with a one-cycle load pulse. On RTI it pops the return address and the status word. It goes back to the user stack if the restored mode is user. An RTI issued from user code performs no memory access and raises a one-cycle privilege-fault flag. Every memory access goes through a request/ready port that may stall for any number of cycles.

Top module: `privSeq`

## Requirements
- R1: After reset the status word is 0x0000 (supervisor, priority 0, codes 0), the stack pointer equals RESET_SSP (default 0x3000), and busy, memReq, pcLoad and privFault are all low.
- R2: When an entry starts in user mode, the current stack pointer is parked as the user pointer and the stack pointer is loaded from the parked supervisor pointer. In supervisor mode the stack pointer is used as it is.
- R3: An entry writes the status word at SP-1 and then the return address at SP-2, so SP ends two below its starting supervisor value. Each push decrements SP and then writes at the new SP.
- R4: An interrupt saves curPc-1 and sets bits [10:8] to intPri. A trap saves curPc unchanged and leaves the priority field as it was.
- R5: The handler address is read from word {INT_TABLE (default 0x01), intVec} for an interrupt and from {0x00, trapVec} for a trap. The word read is presented on newPc together with a one-cycle pcLoad pulse.
- R6: Once an entry has finished, bit 15 of the status word is 0. The condition codes keep the value they had before the entry.
- R7: RTI in supervisor mode reads the new PC at SP, then the status word at SP+1, and leaves SP two higher. newPc carries the popped PC with a pcLoad pulse.
- R8: If the restored status word has bit 15 set, the stack pointer after the pops is parked as the supervisor pointer and SP is loaded from the parked user pointer.
- R9: RTI started in user mode makes no memory request, leaves the status word and SP unchanged, pulses privFault for one cycle, and does not pulse pcLoad.
- R10: While memReq is high and memRdy is low, memAddr, memWdata and memWe hold their values.
- R11: busy is high from the cycle after an accepted start through the pcLoad or privFault cycle. Start requests and ccWe that arrive while busy are ignored.
- R12: If several starts arrive in the same idle cycle, interrupt is taken over trap, and trap over RTI.
- R13: When the block is idle and no start is present, ccWe loads ccIn into bits [2:0] of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startInt | input | 1 | Request interrupt entry |
| startTrap | input | 1 | Request trap entry |
| startRet | input | 1 | Request return from interrupt |
| intVec | input | 8 | Interrupt vector |
| intPri | input | 3 | Priority of the interrupt being serviced |
| trapVec | input | 8 | Trap vector |
| curPc | input | 16 | Current PC (already incremented) |
| ccWe | input | 1 | Condition-code write enable |
| ccIn | input | 3 | New condition codes |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 16 | Memory write data |
| memWe | output | 1 | Memory write (1) or read (0) |
| memReq | output | 1 | Memory request |
| memRdy | input | 1 | Memory ready; completes the access this cycle |
| memRdata | input | 16 | Memory read data, valid with memRdy |
| newPc | output | 16 | Handler or return address |
| pcLoad | output | 1 | One-cycle pulse: newPc is valid, resume fetch |
| busy | output | 1 | Sequence in progress |
| privFault | output | 1 | One-cycle privilege-violation pulse |
| psrOut | output | 16 | Current status word |
| spOut | output | 16 | Current stack pointer |

## Verification
The bench sweeps trap and interrupt vectors, priorities and memory stall lengths, and pairs each entry with an RTI. A stack-direction or ordering bug would therefore show up as swapped or misplaced words in the model memory. The user-to-supervisor round trip checks that both parked pointers survive. A design that swapped stacks on the wrong mode bit would leave SP at the wrong base after the return. A user-mode RTI is checked for no memory traffic and an unchanged state, since a design that popped anyway would corrupt SP. Starts and condition-code writes issued mid-sequence are checked to have no effect. Simultaneous starts must follow the interrupt-first order, which is visible in the table prefix of the vector read.

// File: rtl/privSeqPkg.sv
package privSeqPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_PSR, S_PUSH_PC, S_VEC, S_POP_PC, S_POP_PSR, S_DONE, S_FAULT
  } seqState_t;

  typedef enum logic [1:0] {A_SP_DEC, A_SP, A_VEC} addrSel_t;

  typedef struct packed {
    logic     acceptEntry;
    logic     entryInt;
    logic     ccAllow;
    logic     memGo;
    logic     memWr;
    addrSel_t addrSel;
    logic     wrPc;
    logic     stepDown;
    logic     stepUp;
    logic     enterSup;
    logic     loadPcMem;
    logic     loadPsrMem;
  } seqCtl_t;

endpackage

// File: rtl/privSeqCtrl.sv
module privSeqCtrl
  import privSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startInt,
  input  logic    startTrap,
  input  logic    startRet,
  input  logic    memRdy,
  input  logic    psrPriv,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    fault
);

  seqState_t state, stateNxt;
  logic goInt, goTrap, goRet, idle, isPush, isPop, isMem;

  assign idle   = (state == S_IDLE);
  assign goInt  = startInt;
  assign goTrap = !startInt && startTrap;
  assign goRet  = !startInt && !startTrap && startRet;
  assign isPush = (state == S_PUSH_PSR) || (state == S_PUSH_PC);
  assign isPop  = (state == S_POP_PC) || (state == S_POP_PSR);
  assign isMem  = isPush || isPop || (state == S_VEC);

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE: begin
        if (goInt || goTrap) stateNxt = S_PUSH_PSR;
        else if (goRet)      stateNxt = psrPriv ? S_FAULT : S_POP_PC;
      end
      S_PUSH_PSR: if (memRdy) stateNxt = S_PUSH_PC;
      S_PUSH_PC:  if (memRdy) stateNxt = S_VEC;
      S_VEC:      if (memRdy) stateNxt = S_DONE;
      S_POP_PC:   if (memRdy) stateNxt = S_POP_PSR;
      S_POP_PSR:  if (memRdy) stateNxt = S_DONE;
      S_DONE:     stateNxt = S_IDLE;
      S_FAULT:    stateNxt = S_IDLE;
      default:    stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl.acceptEntry = idle && (goInt || goTrap);
    ctl.entryInt    = goInt;
    ctl.ccAllow     = idle && !startInt && !startTrap && !startRet;
    ctl.memGo       = isMem;
    ctl.memWr       = isPush;
    ctl.addrSel     = isPush ? A_SP_DEC : (isPop ? A_SP : A_VEC);
    ctl.wrPc        = (state == S_PUSH_PC);
    ctl.stepDown    = isPush && memRdy;
    ctl.stepUp      = isPop && memRdy;
    ctl.enterSup    = (state == S_PUSH_PC) && memRdy;
    ctl.loadPcMem   = ((state == S_VEC) || (state == S_POP_PC)) && memRdy;
    ctl.loadPsrMem  = (state == S_POP_PSR) && memRdy;
  end

  assign busy  = !idle;
  assign done  = (state == S_DONE);
  assign fault = (state == S_FAULT);

  // R6: the vector fetch only ever runs with supervisor privilege
  a_r6_vec_supervisor: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_VEC) |-> !psrPriv);

  // R9: a user-mode return is refused without touching memory
  a_r9_fault_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!isMem && !done));

  // R11: a start accepted while idle leaves busy high in the next cycle
  a_r11_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (idle && (startInt || startTrap || startRet)) |=> busy);

endmodule

// File: rtl/privSeqPath.sv
module privSeqPath
  import privSeqPkg::*;
#(
  parameter int DW        = 16,
  parameter int VEC_W     = 8,
  parameter int PRI_W     = 3,
  parameter int CC_W      = 3,
  parameter int INT_TABLE = 1,
  parameter logic [DW-1:0] RESET_SSP = 16'h3000,
  parameter logic [DW-1:0] RESET_USP = 16'hFE00
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [VEC_W-1:0] intVec,
  input  logic [PRI_W-1:0] intPri,
  input  logic [VEC_W-1:0] trapVec,
  input  logic [DW-1:0]    curPc,
  input  logic             ccWe,
  input  logic [CC_W-1:0]  ccIn,
  input  logic             memRdy,
  input  logic [DW-1:0]    memRdata,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic             memWe,
  output logic             memReq,
  output logic [DW-1:0]    newPc,
  output logic             psrPriv,
  output logic [DW-1:0]    psrOut,
  output logic [DW-1:0]    spOut
);

  localparam int PRIV_BIT = DW - 1;
  localparam int PRI_LSB  = 8;
  localparam int TBL_W    = DW - VEC_W;
  localparam logic [DW-1:0] PSR_MASK =
    (DW'(1) << PRIV_BIT) | (((DW'(1) << PRI_W) - DW'(1)) << PRI_LSB) | ((DW'(1) << CC_W) - DW'(1));

  logic [DW-1:0]    psr, sp, usp, ssp, pcReg;
  logic [VEC_W-1:0] vecReg;
  logic [PRI_W-1:0] priReg;
  logic             kindInt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psr     <= '0;
      sp      <= RESET_SSP;
      ssp     <= RESET_SSP;
      usp     <= RESET_USP;
      pcReg   <= '0;
      vecReg  <= '0;
      priReg  <= '0;
      kindInt <= 1'b0;
    end else begin
      if (ctl.acceptEntry) begin
        kindInt <= ctl.entryInt;
        vecReg  <= ctl.entryInt ? intVec : trapVec;
        priReg  <= intPri;
        pcReg   <= ctl.entryInt ? (curPc - DW'(1)) : curPc;
        if (psr[PRIV_BIT]) begin
          usp <= sp;
          sp  <= ssp;
        end
      end
      if (ctl.stepDown) sp <= sp - DW'(1);
      if (ctl.stepUp) begin
        if (ctl.loadPsrMem && memRdata[PRIV_BIT]) begin
          ssp <= sp + DW'(1);
          sp  <= usp;
        end else begin
          sp <= sp + DW'(1);
        end
      end
      if (ctl.enterSup) begin
        psr[PRIV_BIT] <= 1'b0;
        if (kindInt) psr[PRI_LSB +: PRI_W] <= priReg;
      end
      if (ctl.loadPcMem)  pcReg <= memRdata;
      if (ctl.loadPsrMem) psr   <= memRdata & PSR_MASK;
      if (ctl.ccAllow && ccWe) psr[CC_W-1:0] <= ccIn;
    end
  end

  always_comb begin
    unique case (ctl.addrSel)
      A_SP_DEC: memAddr = sp - DW'(1);
      A_SP:     memAddr = sp;
      default:  memAddr = {(kindInt ? TBL_W'(INT_TABLE) : TBL_W'(0)), vecReg};
    endcase
  end

  assign memWdata = ctl.wrPc ? pcReg : psr;
  assign memWe    = ctl.memWr;
  assign memReq   = ctl.memGo;
  assign newPc    = pcReg;
  assign psrPriv  = psr[PRIV_BIT];
  assign psrOut   = psr;
  assign spOut    = sp;

  // R10: a stalled access keeps its address, data and direction
  a_r10_hold_access: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdy) |=> (memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe)));

  // R3: a completed push leaves SP pointing at the word just written
  a_r3_push_sp: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memRdy) |=> (sp == $past(memAddr)));

  // R7: a completed pop moves SP upward by one unless the user stack is restored
  a_r7_pop_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memRdy && ctl.addrSel == A_SP && !(ctl.loadPsrMem && memRdata[PRIV_BIT]))
      |=> (sp == $past(memAddr) + DW'(1)));

endmodule

// File: rtl/privSeq.sv
module privSeq
  import privSeqPkg::*;
#(
  parameter int DW        = 16,
  parameter int VEC_W     = 8,
  parameter int PRI_W     = 3,
  parameter int CC_W      = 3,
  parameter int INT_TABLE = 1,
  parameter logic [DW-1:0] RESET_SSP = 16'h3000,
  parameter logic [DW-1:0] RESET_USP = 16'hFE00
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startInt,
  input  logic             startTrap,
  input  logic             startRet,
  input  logic [VEC_W-1:0] intVec,
  input  logic [PRI_W-1:0] intPri,
  input  logic [VEC_W-1:0] trapVec,
  input  logic [DW-1:0]    curPc,
  input  logic             ccWe,
  input  logic [CC_W-1:0]  ccIn,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  output logic             memWe,
  output logic             memReq,
  input  logic             memRdy,
  input  logic [DW-1:0]    memRdata,
  output logic [DW-1:0]    newPc,
  output logic             pcLoad,
  output logic             busy,
  output logic             privFault,
  output logic [DW-1:0]    psrOut,
  output logic [DW-1:0]    spOut
);

  seqCtl_t ctl;
  logic    psrPriv;

  privSeqCtrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .startInt(startInt), .startTrap(startTrap), .startRet(startRet),
    .memRdy(memRdy), .psrPriv(psrPriv),
    .ctl(ctl), .busy(busy), .done(pcLoad), .fault(privFault)
  );

  privSeqPath #(
    .DW(DW), .VEC_W(VEC_W), .PRI_W(PRI_W), .CC_W(CC_W),
    .INT_TABLE(INT_TABLE), .RESET_SSP(RESET_SSP), .RESET_USP(RESET_USP)
  ) i_path (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .intVec(intVec), .intPri(intPri), .trapVec(trapVec), .curPc(curPc),
    .ccWe(ccWe), .ccIn(ccIn), .memRdy(memRdy), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memReq(memReq),
    .newPc(newPc), .psrPriv(psrPriv), .psrOut(psrOut), .spOut(spOut)
  );

  // R9: a refused return only happens from user mode
  a_r9_fault_user: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> psrOut[DW-1]);

  // R11: memory traffic and completion only occur inside a busy window
  a_r11_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || pcLoad) |-> busy);

  // R5: completion is a single-cycle pulse
  a_r5_load_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad);

endmodule

// File: tb/test_privSeq.sv
module test_privSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startInt = 0, startTrap = 0, startRet = 0;
  logic [7:0]  intVec = 0, trapVec = 0;
  logic [2:0]  intPri = 0, ccIn = 0;
  logic [15:0] curPc = 0;
  logic        ccWe = 0;
  logic [15:0] memAddr, memWdata, memRdata, newPc, psrOut, spOut;
  logic        memWe, memReq, memRdy, pcLoad, busy, privFault;

  always #4 clk = ~clk;

  privSeq i_privSeq (
    .clk(clk), .rstN(rstN), .startInt(startInt), .startTrap(startTrap), .startRet(startRet),
    .intVec(intVec), .intPri(intPri), .trapVec(trapVec), .curPc(curPc),
    .ccWe(ccWe), .ccIn(ccIn), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memReq(memReq), .memRdy(memRdy), .memRdata(memRdata), .newPc(newPc), .pcLoad(pcLoad),
    .busy(busy), .privFault(privFault), .psrOut(psrOut), .spOut(spOut)
  );

  // memory model with programmable stall
  logic [15:0] mem [logic [15:0]];
  int stallSet = 0, waitCnt = 0, accCnt = 0, holdErr = 0;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic [15:0] lastPc;
  bit sawFault, sawLoad;
  logic        prevPend = 0;
  logic [15:0] prevAddr = 0, prevData = 0;

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  assign memRdy   = memReq && (waitCnt >= stallSet);
  assign memRdata = rd(memAddr);

  always @(posedge clk) begin
    if (memReq && !memRdy) waitCnt <= waitCnt + 1;
    else                   waitCnt <= 0;
    if (memReq && memRdy) begin
      accCnt <= accCnt + 1;
      if (memWe) mem[memAddr] = memWdata;
    end
  end

  // R10 observer: a stalled access must hold steady
  always @(negedge clk) begin
    if (rstN && prevPend && (!memReq || memAddr !== prevAddr || (memWe && memWdata !== prevData)))
      holdErr++;
    prevPend = memReq && !memRdy;
    prevAddr = memAddr;
    prevData = memWdata;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      summary();
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic waitEnd();
    sawFault = 0; sawLoad = 0;
    for (int i = 0; i < 400; i++) begin
      if (pcLoad) begin sawLoad = 1; lastPc = newPc; break; end
      if (privFault) begin sawFault = 1; break; end
      @(negedge clk);
    end
    if (!sawLoad && !sawFault) begin
      bad++; total++;
      $display("FAIL timeout act=none exp=end");
    end
    @(negedge clk);
  endtask

  task automatic launch(input bit i, input bit t, input bit r);
    startInt = i; startTrap = t; startRet = r;
    @(negedge clk);
    startInt = 0; startTrap = 0; startRet = 0;
  endtask

  task automatic doOp(input bit i, input bit t, input bit r);
    accCnt = 0;
    launch(i, t, r);
    waitEnd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 psr", psrOut, 16'h0000);
    check("R1 sp", spOut, 16'h3000);
    check("R1 idle", {12'd0, busy, memReq, pcLoad, privFault}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);

    // R13: condition codes loadable when idle
    ccIn = 3'b101; ccWe = 1;
    @(negedge clk);
    ccWe = 0;
    check("R13 cc write", psrOut, 16'h0005);

    // R3 R4 R5 R6 R7: trap/return sweep from supervisor over stalls and vectors
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0]  v;
        logic [15:0] pc, h;
        stallSet = s;
        v = 8'h20 + 8'(k * 3);
        pc = 16'h4000 + 16'(k * 17 + s);
        h = 16'h0500 + 16'(k * 16 + s);
        mem[{8'h00, v}] = h;
        trapVec = v; curPc = pc;
        doOp(0, 1, 0);
        check("R3 sp after trap", spOut, 16'h2FFE);
        check("R3 pushed psr", rd(16'h2FFF), 16'h0005);
        check("R4 trap pushed pc", rd(16'h2FFE), pc);
        check("R5 trap handler", lastPc, h);
        check("R6 psr after trap", psrOut, 16'h0005);
        doOp(0, 0, 1);
        check("R7 rti pc", lastPc, pc);
        check("R7 rti sp", spOut, 16'h3000);
        check("R7 rti psr", psrOut, 16'h0005);
      end
    end

    // R4 R5: interrupt sweep from supervisor over priorities
    for (int k = 0; k < 7; k++) begin
      logic [7:0]  v;
      logic [15:0] pc, h;
      stallSet = k % 3;
      v = 8'h80 + 8'(k);
      pc = 16'h6000 + 16'(k * 5);
      h = 16'h0900 + 16'(k);
      mem[{8'h01, v}] = h;
      intVec = v; intPri = 3'(k + 1); curPc = pc;
      doOp(1, 0, 0);
      check("R4 int pushed pc", rd(16'h2FFE), pc - 16'd1);
      check("R4 int priority", psrOut, {5'd0, 3'(k + 1), 5'd0, 3'b101});
      check("R5 int handler", lastPc, h);
      doOp(0, 0, 1);
      check("R7 rti after int", psrOut, 16'h0005);
      check("R7 rti pc after int", lastPc, pc - 16'd1);
    end

    // R8: drop to user mode through a crafted frame
    stallSet = 1;
    trapVec = 8'h30; curPc = 16'h4444; mem[16'h0030] = 16'h0600;
    doOp(0, 1, 0);
    mem[16'h2FFF] = 16'hFB02;   // mode 1, priority 3, codes 2, stray bits set
    mem[16'h2FFE] = 16'h1234;
    doOp(0, 0, 1);
    check("R8 user psr masked", psrOut, 16'h8302);
    check("R8 user sp", spOut, 16'hFE00);
    check("R8 user pc", lastPc, 16'h1234);

    // R9: return from user mode is refused
    doOp(0, 0, 1);
    check("R9 fault seen", {15'd0, sawFault}, 16'h0001);
    check("R9 no load", {15'd0, sawLoad}, 16'h0000);
    check("R9 no mem access", 16'(accCnt), 16'h0000);
    check("R9 psr kept", psrOut, 16'h8302);
    check("R9 sp kept", spOut, 16'hFE00);

    // R2: interrupt from user switches stacks
    intVec = 8'h80; intPri = 3'd5; curPc = 16'h1235; mem[16'h0180] = 16'h0700;
    doOp(1, 0, 0);
    check("R2 sp on sup stack", spOut, 16'h2FFE);
    check("R2 pushed user psr", rd(16'h2FFF), 16'h8302);
    check("R2 pushed pc", rd(16'h2FFE), 16'h1234);
    check("R6 sup after int", psrOut, 16'h0502);
    check("R5 handler", lastPc, 16'h0700);
    doOp(0, 0, 1);
    check("R8 usp restored", spOut, 16'hFE00);
    check("R8 psr user again", psrOut, 16'h8302);

    // R4 R6: trap from user leaves priority
    trapVec = 8'h25; curPc = 16'h2000; mem[16'h0025] = 16'h0800;
    doOp(0, 1, 0);
    check("R6 trap from user psr", psrOut, 16'h0302);
    check("R2 ssp reused", spOut, 16'h2FFE);

    // R11: starts and ccWe during busy are ignored
    stallSet = 3;
    doOp(0, 0, 1);   // back to user
    accCnt = 0;
    trapVec = 8'h21; curPc = 16'h2100; mem[16'h0021] = 16'h0810;
    launch(0, 1, 0);
    check("R11 busy", {15'd0, busy}, 16'h0001);
    startInt = 1; startRet = 1; ccWe = 1; ccIn = 3'b111;
    @(negedge clk);
    @(negedge clk);
    startInt = 0; startRet = 0; ccWe = 0;
    waitEnd();
    repeat (6) @(negedge clk);
    check("R11 access count", 16'(accCnt), 16'd3);
    check("R11 handler", lastPc, 16'h0810);
    check("R11 cc unchanged", psrOut, 16'h0302);
    check("R11 idle after", {15'd0, busy}, 16'h0000);
    check("R10 stall hold", 16'(holdErr), 16'h0000);

    // R12: all starts together, interrupt wins
    stallSet = 0;
    doOp(0, 0, 1);
    intVec = 8'h81; intPri = 3'd2; trapVec = 8'h22; curPc = 16'h3333;
    mem[16'h0181] = 16'h0A00; mem[16'h0022] = 16'h0B00;
    doOp(1, 1, 1);
    check("R12 int chosen", lastPc, 16'h0A00);
    check("R12 int priority", psrOut, 16'h0202);
    doOp(0, 1, 1);
    check("R12 trap over rti", lastPc, 16'h0B00);
    summary();
  end

endmodule